// File: doc/BRIEF.md
# Memory-Mapped I/O Router

This block sits on the data side of a small processor and steers every load and store either to a 64 KB data RAM or to a handful of I/O registers. It keeps the low 17 bits of the request address. When bit 16 is clear, the access goes straight to the RAM port with byte enables and lane-replicated write data. When bit 16 is set, the access is decoded against a short list of exact I/O addresses.

The I/O space holds several registers:
- a console port that sends bytes out and returns a received byte;
- a free-running timer that counts in units of 100 clock cycles;
- a debug strobe;
- a sticky exit flag;
- a guarded path into program memory, which has its own address space.

Program memory can only be written in three steps. A key value is written to an unlock register. A start address is loaded into a pointer register. Each write to a data register then stores one item at the pointer and advances the pointer by 4. While the path is locked, writes to the data register are dropped.

Reads answer one cycle after the request. I/O side effects also appear one cycle after the request that caused them. The RAM request itself is passed through combinationally.

Top module: `mmio_router`

## Requirements
- R1: Only bits 16:0 of `req_addr` are used. If bit 16 is 0, `ram_req` is high in the same cycle, and `ram_addr` is bits 15:0 of the address after the size alignment of R2. If bit 16 is 1, `ram_req` stays low.
- R2: `req_size` selects the access size: 0 is a byte, 1 is a halfword, 2 is a word. A halfword clears address bit 0 and a word clears bits 1:0. `ram_be` bit i enables byte lane i, which is data bits 8i+7:8i. Write data is replicated across the lanes: the byte four times, the halfword twice.
- R3: A read raises `resp_valid` for one cycle, one cycle after the request. A RAM read returns the addressed byte or halfword from the lane selected by the aligned address, zero-extended. A word read returns the full word.
- R4: A write to 0x1FC80 unlocks the program-memory path if the data equals 0x1337F7D1, and locks it for any other value. The path is locked after reset.
- R5: A write to 0x1FC84 loads the low 18 bits of the data into the program-memory pointer.
- R6: A write to 0x1FC88 while unlocked pulses `pm_we` one cycle later. The pulse carries the pointer aligned by size, lane enables and replicated data as in R2, and the pointer then advances by 4. While locked, the write produces no pulse and the pointer does not move.
- R7: A write to 0x10000 pulses `con_tx_valid` one cycle later with data bits 7:0. A read of 0x10000 returns `con_rx_data`, zero-extended.
- R8: A read of 0x1FFF4 returns the number of complete 100-cycle periods since reset.
- R9: A write to 0x1FFF8 pulses `dbg_valid` one cycle later with the full data word. A write to 0x1FFFC sets `halt`, which stays high until reset. All event outputs and `halt` are low after reset.
- R10: A read of any other I/O address returns zero and pulses `illegal` together with `resp_valid`. A write to any other I/O address has no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Byte address (bits 16:0 used) |
| req_wdata | input | 32 | Store data, right-aligned |
| resp_valid | output | 1 | Read response valid |
| resp_rdata | output | 32 | Read response data |
| illegal | output | 1 | Unmapped I/O read |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write |
| ram_addr | output | 16 | RAM byte address, aligned |
| ram_be | output | 4 | RAM byte-lane enables |
| ram_wdata | output | 32 | RAM write data, lane-replicated |
| ram_rdata | input | 32 | RAM read word, one cycle after request |
| pm_we | output | 1 | Program-memory write pulse |
| pm_addr | output | 18 | Program-memory byte address |
| pm_be | output | 4 | Program-memory lane enables |
| pm_wdata | output | 32 | Program-memory write data |
| con_tx_valid | output | 1 | Console byte out strobe |
| con_tx_data | output | 8 | Console byte out |
| con_rx_data | input | 8 | Console byte in |
| dbg_valid | output | 1 | Debug strobe |
| dbg_data | output | 32 | Debug word |
| halt | output | 1 | Sticky exit flag |

## Verification
The assertions rely on three things about the inputs:
- at most one request is presented per cycle;
- `req_size` never takes the value 3;
- the RAM returns the addressed word exactly one cycle after a read request.

The stimulus drives every request one nanosecond after a rising edge and uses only sizes 0 to 2. It also models the RAM with a one-cycle registered read, so the read-response and pointer-step properties see only the traffic they assume.

// File: rtl/mmio_router.sv
module mmio_router #(
  parameter int          RAM_AW     = 16,
  parameter int          PM_AW      = 18,
  parameter int          TICK_DIV   = 100,
  parameter logic [31:0] UNLOCK_KEY = 32'h1337F7D1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic              illegal,
  output logic              ram_req,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [3:0]        ram_be,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata,
  output logic              pm_we,
  output logic [PM_AW-1:0]  pm_addr,
  output logic [3:0]        pm_be,
  output logic [31:0]       pm_wdata,
  output logic              con_tx_valid,
  output logic [7:0]        con_tx_data,
  input  logic [7:0]        con_rx_data,
  output logic              dbg_valid,
  output logic [31:0]       dbg_data,
  output logic              halt
);

  localparam int AW = 17;
  localparam int PW = $clog2(TICK_DIV);
  localparam logic [AW-1:0] A_CON  = 17'h10000;
  localparam logic [AW-1:0] A_KEY  = 17'h1FC80;
  localparam logic [AW-1:0] A_PTR  = 17'h1FC84;
  localparam logic [AW-1:0] A_PMD  = 17'h1FC88;
  localparam logic [AW-1:0] A_TIME = 17'h1FFF4;
  localparam logic [AW-1:0] A_DBG  = 17'h1FFF8;
  localparam logic [AW-1:0] A_EXIT = 17'h1FFFC;

  // returns {aligned low bits, lane enables}
  function automatic logic [5:0] lanes(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    lanes = {lo, 4'b0001 << lo};
      2'd1:    lanes = {lo[1], 1'b0, (lo[1] ? 4'b1100 : 4'b0011)};
      default: lanes = {2'b00, 4'b1111};
    endcase
  endfunction

  logic [AW-1:0] a;
  logic [5:0]    req_ln, pm_ln;
  logic [31:0]   wrep;
  logic          io_wr, io_rd;

  assign a      = req_addr[AW-1:0];
  assign req_ln = lanes(req_size, a[1:0]);
  assign io_wr  = req_valid && a[16] && req_write;
  assign io_rd  = req_valid && a[16] && !req_write;

  always_comb
    case (req_size)
      2'd0:    wrep = {4{req_wdata[7:0]}};
      2'd1:    wrep = {2{req_wdata[15:0]}};
      default: wrep = req_wdata;
    endcase

  assign ram_req   = req_valid && !a[16];
  assign ram_we    = req_write;
  assign ram_addr  = {a[RAM_AW-1:2], req_ln[5:4]};
  assign ram_be    = req_ln[3:0];
  assign ram_wdata = wrep;

  logic              unlocked;
  logic [PM_AW-1:0]  pm_ptr;
  logic [PW-1:0]     pre;
  logic [31:0]       ticks;
  logic              rd_ram_q;
  logic [1:0]        rd_size_q, rd_lo_q;
  logic [31:0]       io_rdata_q, ram_sh;

  assign pm_ln = lanes(req_size, pm_ptr[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked     <= 1'b0;
      pm_ptr       <= '0;
      pre          <= '0;
      ticks        <= '0;
      resp_valid   <= 1'b0;
      rd_ram_q     <= 1'b0;
      rd_size_q    <= '0;
      rd_lo_q      <= '0;
      io_rdata_q   <= '0;
      illegal      <= 1'b0;
      con_tx_valid <= 1'b0;
      con_tx_data  <= '0;
      dbg_valid    <= 1'b0;
      dbg_data     <= '0;
      halt         <= 1'b0;
      pm_we        <= 1'b0;
      pm_addr      <= '0;
      pm_be        <= '0;
      pm_wdata     <= '0;
    end else begin
      if (pre == PW'(TICK_DIV - 1)) begin
        pre   <= '0;
        ticks <= ticks + 32'd1;
      end else begin
        pre <= pre + 1'b1;
      end

      resp_valid <= req_valid && !req_write;
      rd_ram_q   <= !a[16];
      rd_size_q  <= req_size;
      rd_lo_q    <= req_ln[5:4];
      illegal    <= io_rd && (a != A_CON) && (a != A_TIME);
      io_rdata_q <= (a == A_CON)  ? {24'b0, con_rx_data} :
                    (a == A_TIME) ? ticks : 32'b0;

      con_tx_valid <= io_wr && (a == A_CON);
      if (io_wr && (a == A_CON)) con_tx_data <= req_wdata[7:0];

      dbg_valid <= io_wr && (a == A_DBG);
      if (io_wr && (a == A_DBG)) dbg_data <= req_wdata;

      if (io_wr && (a == A_EXIT)) halt <= 1'b1;

      if (io_wr && (a == A_KEY)) unlocked <= (req_wdata == UNLOCK_KEY);

      pm_we <= io_wr && (a == A_PMD) && unlocked;
      if (io_wr && (a == A_PTR)) begin
        pm_ptr <= req_wdata[PM_AW-1:0];
      end else if (io_wr && (a == A_PMD) && unlocked) begin
        pm_addr  <= {pm_ptr[PM_AW-1:2], pm_ln[5:4]};
        pm_be    <= pm_ln[3:0];
        pm_wdata <= wrep;
        pm_ptr   <= pm_ptr + PM_AW'(4);
      end
    end
  end

  assign ram_sh = ram_rdata >> {rd_lo_q, 3'b000};

  always_comb begin
    resp_rdata = '0;
    if (resp_valid) begin
      if (!rd_ram_q)              resp_rdata = io_rdata_q;
      else if (rd_size_q == 2'd0) resp_rdata = {24'b0, ram_sh[7:0]};
      else if (rd_size_q == 2'd1) resp_rdata = {16'b0, ram_sh[15:0]};
      else                        resp_rdata = ram_rdata;
    end
  end

  AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) resp_valid |-> $past(req_valid && !req_write)); // R3
  AST_PM_ONLY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n) pm_we |-> $past(unlocked)); // R4
  AST_PM_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) pm_we |-> (pm_ptr == $past(pm_ptr) + PM_AW'(4))); // R6
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n) !$stable(ticks) |-> (ticks == $past(ticks) + 32'd1) && ($past(pre) == PW'(TICK_DIV - 1))); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halt |=> halt); // R9
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> resp_valid && (resp_rdata == 32'b0)); // R10
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({con_tx_valid, dbg_valid, pm_we, resp_valid})); // R7

endmodule

// File: tb/mmio_router_test.sv
module mmio_router_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_write;
  logic [1:0] req_size;
  logic [31:0] req_addr, req_wdata;
  logic resp_valid, illegal, ram_req, ram_we, pm_we, con_tx_valid, dbg_valid, halt;
  logic [31:0] resp_rdata, ram_wdata, pm_wdata, dbg_data;
  logic [31:0] ram_rdata;
  logic [15:0] ram_addr;
  logic [17:0] pm_addr;
  logic [3:0] ram_be, pm_be;
  logic [7:0] con_tx_data, con_rx_data;

  mmio_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .illegal(illegal),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .pm_we(pm_we), .pm_addr(pm_addr),
    .pm_be(pm_be), .pm_wdata(pm_wdata), .con_tx_valid(con_tx_valid),
    .con_tx_data(con_tx_data), .con_rx_data(con_rx_data), .dbg_valid(dbg_valid),
    .dbg_data(dbg_data), .halt(halt)
  );

  // RAM model: one-cycle read latency, byte-lane writes
  logic [31:0] mem [0:255];
  always_ff @(posedge clk) begin
    if (ram_req && ram_we) begin
      for (int i = 0; i < 4; i++)
        if (ram_be[i]) mem[ram_addr[9:2]][8*i +: 8] <= ram_wdata[8*i +: 8];
    end else if (ram_req) begin
      ram_rdata <= mem[ram_addr[9:2]];
    end
  end

  typedef struct {
    int          kind;   // 0 resp, 1 console, 2 debug, 3 pm write
    logic [31:0] data;
    logic [31:0] aux;
    logic        flag;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input logic [31:0] data, input logic [31:0] aux,
                           input logic flag, input string tag);
    exp_t e;
    e.kind = kind; e.data = data; e.aux = aux; e.flag = flag; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic got(input int kind, input logic [31:0] data, input logic [31:0] aux, input logic flag);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL unexpected event kind=%0d actual=%h expected=none", kind, data);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.data !== data || e.aux !== aux || e.flag !== flag) begin
        fails++;
        $display("FAIL %s actual=k%0d %h %h %b expected=k%0d %h %h %b",
                 e.tag, kind, data, aux, flag, e.kind, e.data, e.aux, e.flag);
      end
    end
  endtask

  // monitor: away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (resp_valid) got(0, resp_rdata, 32'b0, illegal);
      if (illegal && !resp_valid) got(0, 32'b0, 32'b0, 1'b1);
      if (con_tx_valid) got(1, {24'b0, con_tx_data}, 32'b0, 1'b0);
      if (dbg_valid) got(2, dbg_data, 32'b0, 1'b0);
      if (pm_we) got(3, pm_wdata, {10'b0, pm_addr, pm_be}, 1'b0);
    end
  end

  task automatic access(input logic w, input logic [1:0] sz, input logic [31:0] ad, input logic [31:0] d);
    @(posedge clk);
    #1;
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = ad; req_wdata = d;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_write = 1'b0;
    end
  endtask

  function automatic logic [31:0] pmx(input logic [17:0] ad, input logic [3:0] be);
    return {10'b0, ad, be};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; con_rx_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset halt", {31'b0, halt}, 32'd0);
    chk("R9 reset events", {28'b0, pm_we, con_tx_valid, dbg_valid, resp_valid}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R8 timer
    idle(10);
    access(1'b0, 2'd2, 32'h0001FFF4, 0); expect_ev(0, 32'd0, 0, 0, "R8 timer early");
    idle(240);
    access(1'b0, 2'd2, 32'h0001FFF4, 0); expect_ev(0, 32'd2, 0, 0, "R8 timer after 250");
    idle(2);

    // R1/R2 RAM writes
    access(1'b1, 2'd2, 32'hFFFE0100, 32'hA1B2C3D4);
    chk("R1 ram_req", {31'b0, ram_req}, 32'd1);
    chk("R1 masked addr", {16'b0, ram_addr}, 32'h0100);
    chk("R2 word be", {28'b0, ram_be}, 32'hF);
    access(1'b1, 2'd2, 32'h00000104, 32'h11223344);
    access(1'b1, 2'd0, 32'h00000101, 32'h0000005E);
    chk("R2 byte be", {28'b0, ram_be}, 32'b0010);
    chk("R2 byte replicate", ram_wdata, 32'h5E5E5E5E);
    access(1'b1, 2'd1, 32'h00000107, 32'h00007788);
    chk("R2 half align", {16'b0, ram_addr}, 32'h0106);
    chk("R2 half be", {28'b0, ram_be}, 32'b1100);
    chk("R2 half replicate", ram_wdata, 32'h77887788);

    // R3 reads
    access(1'b0, 2'd0, 32'h00000102, 0); expect_ev(0, 32'h000000B2, 0, 0, "R3 byte read");
    access(1'b0, 2'd1, 32'h00000103, 0); expect_ev(0, 32'h0000A1B2, 0, 0, "R3 half read bit0 ignored");
    access(1'b0, 2'd2, 32'h00000103, 0); expect_ev(0, 32'hA1B25ED4, 0, 0, "R3 word read bits1:0 ignored");
    access(1'b0, 2'd2, 32'h00000104, 0); expect_ev(0, 32'h77883344, 0, 0, "R3 word after half write");
    access(1'b0, 2'd1, 32'h00000105, 0); expect_ev(0, 32'h00003344, 0, 0, "R3 low half");
    idle(2);

    // R7 console
    access(1'b1, 2'd2, 32'h00010000, 32'h123456C3);
    chk("R1 io no ram_req", {31'b0, ram_req}, 32'd0);
    expect_ev(1, 32'h000000C3, 0, 0, "R7 console out");
    con_rx_data = 8'h5A;
    access(1'b0, 2'd0, 32'h00010000, 0); expect_ev(0, 32'h0000005A, 0, 0, "R7 console in");

    // R9 debug
    access(1'b1, 2'd2, 32'h0001FFF8, 32'hFEEDFACE); expect_ev(2, 32'hFEEDFACE, 0, 0, "R9 debug");

    // R4/R5/R6 program memory path
    access(1'b1, 2'd2, 32'h0001FC84, 32'hFFFC0040);
    access(1'b1, 2'd2, 32'h0001FC88, 32'h99999999);   // locked after reset: dropped
    access(1'b1, 2'd2, 32'h0001FC80, 32'h1337F7D1);
    access(1'b1, 2'd2, 32'h0001FC88, 32'hDEADBEEF);
    expect_ev(3, 32'hDEADBEEF, pmx(18'h00040, 4'hF), 0, "R6 first pm write");
    access(1'b1, 2'd2, 32'h0001FC88, 32'hCAFEF00D);
    expect_ev(3, 32'hCAFEF00D, pmx(18'h00044, 4'hF), 0, "R6 pointer step");
    access(1'b1, 2'd0, 32'h0001FC88, 32'h00000012);
    expect_ev(3, 32'h12121212, pmx(18'h00048, 4'b0001), 0, "R6 byte pm write");
    access(1'b1, 2'd2, 32'h0001FC80, 32'h1337F7D0);   // R4 wrong key relocks
    access(1'b1, 2'd2, 32'h0001FC88, 32'h55555555);   // dropped
    access(1'b1, 2'd2, 32'h0001FC80, 32'h1337F7D1);
    access(1'b1, 2'd2, 32'h0001FC88, 32'h0BADF00D);
    expect_ev(3, 32'h0BADF00D, pmx(18'h0004C, 4'hF), 0, "R4 relock held pointer");
    access(1'b1, 2'd2, 32'h0001FC84, 32'h00000102);   // R5 reload
    access(1'b1, 2'd1, 32'h0001FC88, 32'h0000ABCD);
    expect_ev(3, 32'hABCDABCD, pmx(18'h00102, 4'b1100), 0, "R5 reload and half align");

    // R10 unmapped
    access(1'b0, 2'd2, 32'h0001FFF0, 0); expect_ev(0, 32'h0, 0, 1, "R10 unmapped read");
    access(1'b0, 2'd2, 32'h0001FC84, 0); expect_ev(0, 32'h0, 0, 1, "R10 write-only reg read");
    access(1'b1, 2'd2, 32'h0001FFF0, 32'h77777777);
    access(1'b1, 2'd2, 32'h0001FFF4, 32'h77777777);
    idle(2);
    chk("R10 unmapped write no halt", {31'b0, halt}, 32'd0);

    // R9 exit
    access(1'b1, 2'd2, 32'h0001FFFC, 32'h0);
    idle(2);
    chk("R9 halt set", {31'b0, halt}, 32'd1);
    idle(5);
    chk("R9 halt sticky", {31'b0, halt}, 32'd1);

    idle(4);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL missing events actual=%0d pending expected=0 (first %s)", q.size(), q[0].tag);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule